// File: doc/BRIEF.md
# Breadth-First Search Traversal Engine

This block computes the hop count from one source vertex to every other vertex of a small sparse graph held in on-chip storage. While the engine is idle, a host writes the graph in compressed adjacency form. One memory holds, for each vertex, the index of its first edge; the other holds the target vertex of each edge. The host then presents a source vertex and pulses `start`. When `done` rises, the host reads each vertex's hop count through a combinational read port.

The whole traversal runs as one invocation of a single control loop. Each step takes a vertex from the current-level frontier, fetches its edge range and walks its neighbours. An unvisited neighbour is marked, given its cost and appended to the next-level frontier. The two frontiers are plain arrays with a head index and a tail index. When the current frontier runs dry they trade roles. The run stops at the first level that adds nothing to the next frontier. Before every run, a sequential pass resets the visited flags and the costs.

Top module: `bfs_engine`

## Requirements
- R1: After reset, `busy`, `done` and `costRdValid` are low and `costRdData` is zero.
- R2: A `start` pulse seen while the engine is idle or done raises `busy` and lowers `done` at the next clock edge. Each run first resets every vertex's cost and visited flag, so results of an earlier run do not leak into the next one.
- R3: The source vertex reads back a cost of 0.
- R4: Every vertex reachable from the source reads back its minimum hop count. An edge (u, v) stored between `offset[u]` and `offset[u+1]-1` of the edge memory leads from u to v.
- R5: Every vertex not reachable from the source reads back all ones (255 for an 8-bit cost).
- R6: A vertex already visited is never re-queued and its cost is never overwritten. This holds for self-loops, duplicate edges and edges back to earlier levels, including edges back to the source.
- R7: From the accepted `start` until `done`, `busy` stays high without a break. Level changes happen inside the run, and at most one control strobe is active in any cycle.
- R8: The run ends when a whole level appends no vertex. `done` then stays high, with `busy` low, until the next accepted `start`.
- R9: A `start` pulse while `busy` is high is ignored, and the running traversal keeps its original source.
- R10: `costRdValid` equals `done`. While `done` is high, `costRdData` is the cost of vertex `costRdAddr`. Otherwise it is zero.
- R11: Writes to the offset and edge memories are ignored while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a traversal (one-cycle pulse) |
| srcVtx | input | VW | Source vertex, sampled with `start` |
| busy | output | 1 | Traversal in progress |
| done | output | 1 | Traversal finished, costs readable |
| offWrEn | input | 1 | Offset memory write enable |
| offWrAddr | input | OW | Offset memory index (0..NUM_V) |
| offWrData | input | EW | First-edge index for that vertex |
| colWrEn | input | 1 | Edge memory write enable |
| colWrAddr | input | EAW | Edge memory index |
| colWrData | input | VW | Target vertex of that edge |
| costRdAddr | input | VW | Vertex whose cost is read |
| costRdData | output | COST_W | Hop count, all ones if unreached |
| costRdValid | output | 1 | Read data valid |

## Verification
The assertions take the graph to be well formed. Offsets never decrease, the last offset is at most NUM_E, every edge target and the source are below NUM_V, and `start` lasts one cycle. The bench builds every graph from a per-vertex degree list, so the offsets are monotonic by construction. It draws every target and source from the vertex range. Its only writes during a run are deliberate R11 probes, which the design must drop.

// File: rtl/bfs_pkg.sv
package bfs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CLEAR,
    ST_SEED,
    ST_POP,
    ST_EDGE,
    ST_SWAP,
    ST_DONE
  } bfs_state_t;

  // One-hot command strobes from control to datapath
  typedef struct packed {
    logic launch;    // accept start, capture source
    logic clrStep;   // reset one vertex's cost and visited flag
    logic seed;      // place source in frontier, cost 0
    logic popVtx;    // take next vertex from current frontier
    logic edgeStep;  // examine one neighbour
    logic swapLvl;   // next frontier becomes current
  } bfs_strobe_t;

  typedef struct packed {
    logic clrLast;
    logic curEmpty;
    logic nextEmpty;
    logic edgesDone;
  } bfs_status_t;

endpackage

// File: rtl/bfs_ctrl.sv
module bfs_ctrl
  import bfs_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  bfs_status_t stat,
  output bfs_strobe_t strb,
  output logic        busy,
  output logic        done
);

  bfs_state_t state, stateNxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end

  always_comb begin
    stateNxt = state;
    strb     = '0;
    unique case (state)
      ST_IDLE, ST_DONE: begin
        if (start) begin
          strb.launch = 1'b1;
          stateNxt    = ST_CLEAR;
        end
      end
      ST_CLEAR: begin
        strb.clrStep = 1'b1;
        if (stat.clrLast) stateNxt = ST_SEED;
      end
      ST_SEED: begin
        strb.seed = 1'b1;
        stateNxt  = ST_POP;
      end
      ST_POP: begin
        if (stat.curEmpty) begin
          stateNxt = stat.nextEmpty ? ST_DONE : ST_SWAP;
        end else begin
          strb.popVtx = 1'b1;
          stateNxt    = ST_EDGE;
        end
      end
      ST_EDGE: begin
        if (stat.edgesDone) stateNxt = ST_POP;
        else                strb.edgeStep = 1'b1;
      end
      ST_SWAP: begin
        strb.swapLvl = 1'b1;
        stateNxt     = ST_POP;
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  assign busy = (state != ST_IDLE) && (state != ST_DONE);
  assign done = (state == ST_DONE);

endmodule

// File: rtl/bfs_datapath.sv
module bfs_datapath
  import bfs_pkg::*;
#(
  parameter int NUM_V  = 256,
  parameter int NUM_E  = 1024,
  parameter int COST_W = 8,
  localparam int VW  = $clog2(NUM_V),
  localparam int OW  = $clog2(NUM_V + 1),
  localparam int EW  = $clog2(NUM_E + 1),
  localparam int EAW = $clog2(NUM_E),
  localparam int QW  = VW + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  bfs_strobe_t       strb,
  input  logic              graphWrOk,
  input  logic              done,
  input  logic [VW-1:0]     srcVtx,
  input  logic              offWrEn,
  input  logic [OW-1:0]     offWrAddr,
  input  logic [EW-1:0]     offWrData,
  input  logic              colWrEn,
  input  logic [EAW-1:0]    colWrAddr,
  input  logic [VW-1:0]     colWrData,
  input  logic [VW-1:0]     costRdAddr,
  output logic [COST_W-1:0] costRdData,
  output bfs_status_t       stat
);

  // Graph, frontier and result storage
  logic [EW-1:0]     offMem  [NUM_V+1];
  logic [VW-1:0]     colMem  [NUM_E];
  logic [VW-1:0]     frontQ  [2][NUM_V];
  logic [COST_W-1:0] costMem [NUM_V];
  logic [NUM_V-1:0]  visited;

  logic [VW-1:0]     srcReg;
  logic [VW-1:0]     clrIdx;
  logic              curSel;
  logic [QW-1:0]     curHead, curTail, nextTail;
  logic [EW-1:0]     edgePtr, edgeEnd;
  logic [COST_W-1:0] curCost;

  logic [VW-1:0]     headVtx;
  logic [OW-1:0]     headIdx;
  logic [VW-1:0]     nbVtx;
  logic              nbFresh;
  logic              nxtSel;

  assign nxtSel  = ~curSel;
  assign headVtx = frontQ[curSel][curHead[VW-1:0]];
  assign headIdx = OW'(headVtx);
  assign nbVtx   = colMem[edgePtr[EAW-1:0]];
  assign nbFresh = strb.edgeStep && !visited[nbVtx];

  // Memories: no reset, contents set by host or by the clear pass
  always_ff @(posedge clk) begin
    if (graphWrOk && offWrEn) offMem[offWrAddr] <= offWrData;
    if (graphWrOk && colWrEn) colMem[colWrAddr] <= colWrData;
    if (strb.clrStep) costMem[clrIdx] <= '1;
    if (strb.seed) begin
      costMem[srcReg]   <= '0;
      frontQ[curSel][0] <= srcReg;
    end
    if (nbFresh) begin
      costMem[nbVtx]                     <= curCost + COST_W'(1);
      frontQ[nxtSel][nextTail[VW-1:0]]   <= nbVtx;
    end
  end

  // Control registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      visited  <= '0;
      srcReg   <= '0;
      clrIdx   <= '0;
      curSel   <= 1'b0;
      curHead  <= '0;
      curTail  <= '0;
      nextTail <= '0;
      edgePtr  <= '0;
      edgeEnd  <= '0;
      curCost  <= '0;
    end else begin
      if (strb.launch) begin
        srcReg <= srcVtx;
        clrIdx <= '0;
      end
      if (strb.clrStep) begin
        visited[clrIdx] <= 1'b0;
        clrIdx          <= clrIdx + VW'(1);
      end
      if (strb.seed) begin
        visited[srcReg] <= 1'b1;
        curHead         <= '0;
        curTail         <= QW'(1);
        nextTail        <= '0;
      end
      if (strb.popVtx) begin
        curHead <= curHead + QW'(1);
        edgePtr <= offMem[headIdx];
        edgeEnd <= offMem[headIdx + OW'(1)];
        curCost <= costMem[headVtx];
      end
      if (strb.edgeStep) begin
        edgePtr <= edgePtr + EW'(1);
        if (!visited[nbVtx]) begin
          visited[nbVtx] <= 1'b1;
          nextTail       <= nextTail + QW'(1);
        end
      end
      if (strb.swapLvl) begin
        curSel   <= nxtSel;
        curHead  <= '0;
        curTail  <= nextTail;
        nextTail <= '0;
      end
    end
  end

  assign stat.clrLast   = (clrIdx == VW'(NUM_V - 1));
  assign stat.curEmpty  = (curHead == curTail);
  assign stat.nextEmpty = (nextTail == '0);
  assign stat.edgesDone = (edgePtr == edgeEnd);

  assign costRdData = done ? costMem[costRdAddr] : '0;

endmodule

// File: rtl/bfs_engine.sv
module bfs_engine
  import bfs_pkg::*;
#(
  parameter int NUM_V  = 256,
  parameter int NUM_E  = 1024,
  parameter int COST_W = 8,
  localparam int VW  = $clog2(NUM_V),
  localparam int OW  = $clog2(NUM_V + 1),
  localparam int EW  = $clog2(NUM_E + 1),
  localparam int EAW = $clog2(NUM_E)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [VW-1:0]     srcVtx,
  output logic              busy,
  output logic              done,
  input  logic              offWrEn,
  input  logic [OW-1:0]     offWrAddr,
  input  logic [EW-1:0]     offWrData,
  input  logic              colWrEn,
  input  logic [EAW-1:0]    colWrAddr,
  input  logic [VW-1:0]     colWrData,
  input  logic [VW-1:0]     costRdAddr,
  output logic [COST_W-1:0] costRdData,
  output logic              costRdValid
);

  bfs_strobe_t strb;
  bfs_status_t stat;

  bfs_ctrl u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .start (start),
    .stat  (stat),
    .strb  (strb),
    .busy  (busy),
    .done  (done)
  );

  bfs_datapath #(
    .NUM_V  (NUM_V),
    .NUM_E  (NUM_E),
    .COST_W (COST_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .graphWrOk  (!busy),
    .done       (done),
    .srcVtx     (srcVtx),
    .offWrEn    (offWrEn),
    .offWrAddr  (offWrAddr),
    .offWrData  (offWrData),
    .colWrEn    (colWrEn),
    .colWrAddr  (colWrAddr),
    .colWrData  (colWrData),
    .costRdAddr (costRdAddr),
    .costRdData (costRdData),
    .stat       (stat)
  );

  assign costRdValid = done;

endmodule

// File: rtl/bfs_checker.sv
module bfs_checker
  import bfs_pkg::*;
#(
  parameter int COST_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              costRdValid,
  input logic [COST_W-1:0] costRdData,
  input bfs_strobe_t       strb
);

  p_reset_idle_r1: assert property (@(posedge clk) $rose(rstN) |-> (!busy && !done));

  p_launch_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && start) |=> (busy && !done));

  p_busy_continuous_r7: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> (busy || done));

  p_one_strobe_r7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strb));

  p_busy_done_excl_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(busy && done));

  p_done_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (done && !start) |=> done);

  p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !strb.launch);

  p_read_gated_r10: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> (costRdData == '0 && !costRdValid));

endmodule

bind bfs_engine bfs_checker #(.COST_W(COST_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .start       (start),
  .busy        (busy),
  .done        (done),
  .costRdValid (costRdValid),
  .costRdData  (costRdData),
  .strb        (strb)
);

// File: tb/sim_bfs_engine.sv
`timescale 1ns/1ps
module sim_bfs_engine;

  localparam int NV  = 16;
  localparam int NE  = 48;
  localparam int CW  = 8;
  localparam int VW  = $clog2(NV);
  localparam int OW  = $clog2(NV + 1);
  localparam int EW  = $clog2(NE + 1);
  localparam int EAW = $clog2(NE);
  localparam int INF = (1 << CW) - 1;

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic           start = 1'b0;
  logic [VW-1:0]  srcVtx = '0;
  logic           busy, done;
  logic           offWrEn = 1'b0;
  logic [OW-1:0]  offWrAddr = '0;
  logic [EW-1:0]  offWrData = '0;
  logic           colWrEn = 1'b0;
  logic [EAW-1:0] colWrAddr = '0;
  logic [VW-1:0]  colWrData = '0;
  logic [VW-1:0]  costRdAddr = '0;
  logic [CW-1:0]  costRdData;
  logic           costRdValid;

  int checks = 0;
  int errors = 0;
  int gOff [NV+1];
  int gCol [NE];
  int expCost [NV];

  bfs_engine #(.NUM_V(NV), .NUM_E(NE), .COST_W(CW)) u0 (
    .clk(clk), .rstN(rstN), .start(start), .srcVtx(srcVtx),
    .busy(busy), .done(done),
    .offWrEn(offWrEn), .offWrAddr(offWrAddr), .offWrData(offWrData),
    .colWrEn(colWrEn), .colWrAddr(colWrAddr), .colWrData(colWrData),
    .costRdAddr(costRdAddr), .costRdData(costRdData), .costRdValid(costRdValid)
  );

  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R8 watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic loadGraph();
    for (int v = 0; v <= NV; v++) begin
      @(negedge clk);
      offWrEn = 1'b1; offWrAddr = OW'(v); offWrData = EW'(gOff[v]);
    end
    @(negedge clk); offWrEn = 1'b0;
    for (int e = 0; e < NE; e++) begin
      @(negedge clk);
      colWrEn = 1'b1; colWrAddr = EAW'(e); colWrData = VW'(gCol[e]);
    end
    @(negedge clk); colWrEn = 1'b0;
  endtask

  // Shortest hop counts by repeated relaxation
  task automatic refBfs(input int src);
    for (int v = 0; v < NV; v++) expCost[v] = INF;
    expCost[src] = 0;
    for (int it = 0; it < NV; it++)
      for (int v = 0; v < NV; v++)
        if (expCost[v] != INF)
          for (int e = gOff[v]; e < gOff[v+1]; e++)
            if (expCost[v] + 1 < expCost[gCol[e]]) expCost[gCol[e]] = expCost[v] + 1;
  endtask

  task automatic startRun(input int src);
    @(negedge clk);
    srcVtx = VW'(src); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy && !done, "R2 launch", {busy, done}, 2);
  endtask

  task automatic waitDone();
    while (!done) @(negedge clk);
  endtask

  task automatic checkCosts(input int src, input string tag);
    for (int v = 0; v < NV; v++) begin
      costRdAddr = VW'(v);
      #1;
      if (v == src) chk(costRdData == 0, "R3 source cost", costRdData, 0);
      else if (expCost[v] == INF) chk(costRdData == CW'(INF), {"R5 unreached ", tag}, costRdData, INF);
      else chk(costRdData == CW'(expCost[v]), {"R4 hop count ", tag}, costRdData, expCost[v]);
    end
    chk(costRdValid == 1'b1, "R10 valid with done", costRdValid, 1);
  endtask

  task automatic fullRun(input int src, input string tag);
    refBfs(src);
    startRun(src);
    waitDone();
    checkCosts(src, tag);
  endtask

  task automatic randGraph(input int maxDeg, input int reachLim);
    int e;
    e = 0;
    for (int i = 0; i < NE; i++) gCol[i] = 0;
    for (int v = 0; v < NV; v++) begin
      int d;
      gOff[v] = e;
      d = $urandom_range(maxDeg, 0);
      for (int k = 0; k < d && e < NE; k++) begin
        gCol[e] = (k == 0 && v % 5 == 0) ? v : $urandom_range(reachLim, 0);
        e++;
      end
    end
    gOff[NV] = e;
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(!busy && !done && !costRdValid, "R1 reset flags", {busy, done, costRdValid}, 0);
    chk(costRdData == 0, "R1 reset read data", costRdData, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(!busy && !done, "R1 idle after reset", {busy, done}, 0);

    // Chain 0->1->...->15: one level per vertex
    for (int v = 0; v <= NV; v++) gOff[v] = (v < NV - 1) ? v : NV - 1;
    for (int e = 0; e < NE; e++) gCol[e] = (e < NV - 1) ? e + 1 : 0;
    loadGraph();
    refBfs(0);
    startRun(0);
    chk(costRdData == 0 && !costRdValid, "R10 gated while busy", costRdData, 0);
    // R9: second start during the run, different source
    srcVtx = VW'(5); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(busy, "R9 still busy", busy, 1);
    // R11: graph writes during the run must be dropped
    offWrEn = 1'b1; offWrAddr = OW'(3); offWrData = '0;
    @(negedge clk); offWrEn = 1'b0;
    colWrEn = 1'b1; colWrAddr = EAW'(2); colWrData = VW'(9);
    @(negedge clk); colWrEn = 1'b0;
    begin
      bit brk;
      brk = 1'b0;
      while (!done) begin
        if (!busy) brk = 1'b1;
        @(negedge clk);
      end
      chk(!brk, "R7 busy unbroken", brk, 0);
    end
    checkCosts(0, "chain R9 R11");
    repeat (5) @(negedge clk);
    chk(done && !busy, "R8 done holds", {done, busy}, 2);

    // Rerun from vertex 3: R2 clearing, R11 graph intact
    fullRun(3, "chain from 3 R2 R11");

    // Self-loops, duplicates and back edges to the source
    for (int e = 0; e < NE; e++) gCol[e] = 0;
    gCol[0] = 0; gCol[1] = 1; gCol[2] = 1;
    gCol[3] = 0; gCol[4] = 1; gCol[5] = 2; gCol[6] = 2;
    gCol[7] = 0; gCol[8] = 1; gCol[9] = 2;
    for (int v = 0; v <= NV; v++) gOff[v] = (v == 0) ? 0 : (v == 1) ? 3 : (v == 2) ? 7 : 10;
    loadGraph();
    fullRun(0, "R6 revisits");

    // No edges at all: terminates after the first level
    for (int v = 0; v <= NV; v++) gOff[v] = 0;
    loadGraph();
    fullRun(7, "R8 empty graph");

    // Random sparse graphs with isolated tail vertices
    for (int g = 0; g < 40; g++) begin
      randGraph(3, NV - 3);
      loadGraph();
      fullRun($urandom_range(NV - 1, 0), "random");
      fullRun(g % NV, "random R6");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule